// File: doc/BRIEF.md
# PIO Byte Buffer with Command Capture

This block is the byte buffer that sits behind the data-port register of a storage bus controller. In normal mode, host writes push bytes into a 16-entry ring, and host reads pop them for programmed-I/O transfers. The ring is tracked by a read pointer, a write pointer and a fill count. The fill count is also exported as the flags value. A successful read latches the byte on the read-data output and pulses an interrupt request. A write that would take the fill count past 15 is refused, and the block pulses an overrun error instead.

The protocol engine owns three things: the mode bit, the bus phase and the status response. When the engine sets command-capture mode, host writes go to a separate command buffer with its own length counter. The engine reads that buffer back byte by byte. When the engine loads a two-byte status response, the data ring holds exactly those two bytes, ready for the host to read.

Top module: `pio_byte_buffer`

## Requirements
- R1: A synchronous reset clears the fill count, both pointers, the command length, the mode bit, the read-data latch, the interrupt and the overrun pulse.
- R2: In normal mode, a host write with fill count below 15 stores the byte at the write pointer and raises the count by one. A host write when the count is 15 stores nothing, leaves the count unchanged, and pulses `overrun` high for one cycle.
- R3: In command-capture mode, a host write lands in the command buffer at index `cmd_len`, raises `cmd_len` by one and leaves the fill count untouched. Once `cmd_len` reaches 16, further writes are dropped. `cmd_byte` shows the entry at `cmd_idx` combinationally.
- R4: A host read with a nonzero fill count lowers the count by one and pulses `irq` high for one cycle after the read edge.
- R5: When phase bits [2:1] are 00 (data-out), a read returns 0 and the read pointer holds. For any other phase, the read returns the byte at the read pointer and the pointer advances.
- R6: When a read drains the count to zero, both pointers return to slot 0. A following write and read therefore use slot 0.
- R7: `resp_load` places `resp_b0` in slot 0 and `resp_b1` in slot 1, sets the count to 2 and clears both pointers. Any host read or write in the same cycle is ignored.
- R8: A host read with a fill count of zero keeps `host_rdata` unchanged, gives no `irq` and keeps the count at zero.
- R9: A read and a write in the same cycle both take effect, so the count is unchanged. The overrun decision uses the count at the start of the cycle: at count 15 the write is refused and the count becomes 14.
- R10: `mode_wr` loads the mode bit from `mode_val`. `cmd_clr` sets `cmd_len` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_wr | input | 1 | Load the mode bit |
| mode_val | input | 1 | New mode: 1 = command capture |
| cmd_clr | input | 1 | Clear the command length |
| phase | input | 3 | Bus phase; bits [2:1] = 00 means data-out |
| host_wr | input | 1 | Host write strobe to the data port |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from the data port |
| resp_load | input | 1 | Load the two-byte status response |
| resp_b0 | input | 8 | First response byte |
| resp_b1 | input | 8 | Second response byte |
| cmd_idx | input | 4 | Command buffer read index |
| host_rdata | output | 8 | Latched read byte |
| fill_count | output | 5 | Bytes held in the data ring (flags value) |
| overrun | output | 1 | One-cycle refused-write pulse |
| irq | output | 1 | One-cycle pulse per serviced read |
| cmd_mode | output | 1 | Current mode bit |
| cmd_len | output | 5 | Command bytes captured |
| cmd_byte | output | 8 | Command buffer entry at `cmd_idx` |

## Verification
A host read and a host write can hit the data ring in the same cycle, and that is where the count arithmetic and the overrun rule interact. The bench issues both strobes together mid-stream and expects the count to stay flat and the older byte to come out. It issues them together again at a count of 15 and expects a refused write, an overrun pulse, a count of 14, and a later drain sequence that never contains the refused byte. A status-response load coinciding with a host write is also provoked, and it is judged by a count of exactly 2 followed by reads of the two response bytes.

// File: rtl/pio_byte_buffer.sv
module pio_byte_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode_wr,
  input  logic                        mode_val,
  input  logic                        cmd_clr,
  input  logic [2:0]                  phase,
  input  logic                        host_wr,
  input  logic [DW-1:0]               host_wdata,
  input  logic                        host_rd,
  input  logic                        resp_load,
  input  logic [DW-1:0]               resp_b0,
  input  logic [DW-1:0]               resp_b1,
  input  logic [$clog2(DEPTH)-1:0]    cmd_idx,
  output logic [DW-1:0]               host_rdata,
  output logic [$clog2(DEPTH):0]      fill_count,
  output logic                        overrun,
  output logic                        irq,
  output logic                        cmd_mode,
  output logic [$clog2(DEPTH):0]      cmd_len,
  output logic [DW-1:0]               cmd_byte
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_AT = CW'(DEPTH - 1);
  localparam logic [CW-1:0] CMD_MAX = CW'(DEPTH);

  logic [DW-1:0] ring [DEPTH];
  logic [DW-1:0] cbuf [DEPTH];
  logic [AW-1:0] rp, wp, rp_n, wp_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wr_ok, wr_bad, rd_ok, data_out, cap_ok;

  assign data_out = (phase[2:1] == 2'b00);
  assign wr_ok    = host_wr && !cmd_mode && (cnt != FULL_AT) && !resp_load;
  assign wr_bad   = host_wr && !cmd_mode && (cnt == FULL_AT) && !resp_load;
  assign rd_ok    = host_rd && (cnt != '0) && !resp_load;
  assign cap_ok   = host_wr && cmd_mode && !resp_load && !cmd_clr && (cmd_len < CMD_MAX);
  assign cmd_byte = cbuf[cmd_idx];
  assign fill_count = cnt;

  always_comb begin
    cnt_n = cnt + CW'(wr_ok) - CW'(rd_ok);
    wp_n  = wr_ok ? wp + 1'b1 : wp;
    rp_n  = (rd_ok && !data_out) ? rp + 1'b1 : rp;
    if (rd_ok && cnt_n == '0) begin
      wp_n = '0;
      rp_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (resp_load) begin
      ring[0] <= resp_b0;
      ring[1] <= resp_b1;
    end else if (wr_ok) begin
      ring[wp] <= host_wdata;
    end
    if (cap_ok) cbuf[cmd_len[AW-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      rp         <= '0;
      wp         <= '0;
      cmd_len    <= '0;
      cmd_mode   <= 1'b0;
      host_rdata <= '0;
      irq        <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      irq     <= rd_ok;
      overrun <= wr_bad;
      if (mode_wr) cmd_mode <= mode_val;
      if (cmd_clr) cmd_len <= '0;
      else if (cap_ok) cmd_len <= cmd_len + 1'b1;
      if (resp_load) begin
        cnt <= CW'(2);
        rp  <= '0;
        wp  <= '0;
      end else begin
        cnt <= cnt_n;
        rp  <= rp_n;
        wp  <= wp_n;
        if (rd_ok) host_rdata <= data_out ? '0 : ring[rp];
      end
    end
  end

  p_full_refuse_r2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !cmd_mode && fill_count == FULL_AT && !host_rd && !resp_load)
      |=> (overrun && fill_count == FULL_AT));

  p_capture_keeps_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && cmd_mode && !host_rd && !resp_load) |=> $stable(fill_count));

  p_irq_on_read_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && fill_count != '0 && !resp_load) |=> irq);

  p_resp_count_r7: assert property (@(posedge clk) disable iff (rst)
    resp_load |=> (fill_count == CW'(2)));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && fill_count == '0 && !host_wr && !resp_load)
      |=> (!irq && $stable(host_rdata) && fill_count == '0));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill_count <= FULL_AT);
endmodule

// File: tb/test_pio_byte_buffer.sv
module test_pio_byte_buffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 0, mode_val = 0, cmd_clr = 0;
  logic [2:0] phase = 3'b010;
  logic       host_wr = 0, host_rd = 0, resp_load = 0;
  logic [7:0] host_wdata = 0, resp_b0 = 0, resp_b1 = 0;
  logic [3:0] cmd_idx = 0;
  logic [7:0] host_rdata, cmd_byte;
  logic [4:0] fill_count, cmd_len;
  logic       overrun, irq, cmd_mode;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pio_byte_buffer i_pio_byte_buffer (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val), .cmd_clr(cmd_clr),
    .phase(phase), .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .resp_load(resp_load), .resp_b0(resp_b0), .resp_b1(resp_b1), .cmd_idx(cmd_idx),
    .host_rdata(host_rdata), .fill_count(fill_count), .overrun(overrun), .irq(irq),
    .cmd_mode(cmd_mode), .cmd_len(cmd_len), .cmd_byte(cmd_byte)
  );

  // {wr, rd, wdata, exp_rdata, exp_count, exp_irq}
  localparam logic [23:0] VEC [9] = '{
    {1'b1, 1'b0, 8'hA1, 8'h00, 5'd1, 1'b0},
    {1'b1, 1'b0, 8'hB2, 8'h00, 5'd2, 1'b0},
    {1'b1, 1'b0, 8'hC3, 8'h00, 5'd3, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'hA1, 5'd2, 1'b1},
    {1'b0, 1'b1, 8'h00, 8'hB2, 5'd1, 1'b1},
    {1'b1, 1'b1, 8'hD4, 8'hC3, 5'd1, 1'b1},
    {1'b0, 1'b1, 8'h00, 8'hD4, 5'd0, 1'b1},
    {1'b1, 1'b0, 8'hE5, 8'hD4, 5'd1, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'hE5, 5'd0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic op(input logic w, input logic [7:0] d, input logic r);
    host_wr = w; host_wdata = d; host_rd = r;
    cyc();
    host_wr = 0; host_rd = 0;
  endtask

  task automatic do_reset();
    rst = 1; cyc(); rst = 0;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 0;
    chk("R1 count", int'(fill_count), 0);
    chk("R1 rdata", int'(host_rdata), 0);
    chk("R1 cmd_len", int'(cmd_len), 0);
    chk("R1 mode", int'(cmd_mode), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 R4 R9 vector table, data-in phase
    for (int i = 0; i < 9; i++) begin
      op(VEC[i][23], VEC[i][21:14], VEC[i][22]);
      chk("R2/R4/R9 table rdata", int'(host_rdata), int'(VEC[i][13:6]));
      chk("R2/R4/R9 table count", int'(fill_count), int'(VEC[i][5:1]));
      chk("R4 table irq", int'(irq), int'(VEC[i][0]));
    end

    // R8 empty read
    op(0, 0, 1);
    chk("R8 rdata kept", int'(host_rdata), 8'hE5);
    chk("R8 no irq", int'(irq), 0);
    chk("R8 count", int'(fill_count), 0);

    // R2 overrun at 15
    for (int i = 0; i < 15; i++) op(1, 8'h10 + 8'(i), 0);
    chk("R2 count full", int'(fill_count), 15);
    op(1, 8'hEE, 0);
    chk("R2 overrun pulse", int'(overrun), 1);
    chk("R2 count held", int'(fill_count), 15);
    op(0, 0, 0);
    chk("R2 overrun clears", int'(overrun), 0);
    // R9 read+write at 15
    op(1, 8'hFF, 1);
    chk("R9 overrun", int'(overrun), 1);
    chk("R9 count", int'(fill_count), 14);
    chk("R9 rdata", int'(host_rdata), 8'h10);
    for (int i = 0; i < 14; i++) op(0, 0, 1);
    chk("R2 last byte", int'(host_rdata), 8'h1E);
    chk("R2 drained", int'(fill_count), 0);

    // R5 data-out phase and R6 pointer snap
    op(1, 8'h51, 0);
    op(1, 8'h52, 0);
    phase = 3'b001;
    op(0, 0, 1);
    chk("R5 data-out reads zero", int'(host_rdata), 0);
    chk("R5 count", int'(fill_count), 1);
    phase = 3'b010;
    op(0, 0, 1);
    chk("R5 pointer held", int'(host_rdata), 8'h51);
    op(1, 8'h61, 0);
    op(1, 8'h62, 0);
    op(0, 0, 1);
    phase = 3'b000;
    op(0, 0, 1);
    chk("R6 drained", int'(fill_count), 0);
    phase = 3'b110;
    op(1, 8'h63, 0);
    op(0, 0, 1);
    chk("R6 snap to slot 0", int'(host_rdata), 8'h63);

    // R7 response load with coincident write
    resp_b0 = 8'h02; resp_b1 = 8'h00; resp_load = 1;
    host_wr = 1; host_wdata = 8'h77;
    cyc();
    resp_load = 0; host_wr = 0;
    chk("R7 count", int'(fill_count), 2);
    op(0, 0, 1);
    chk("R7 byte0", int'(host_rdata), 8'h02);
    op(0, 0, 1);
    chk("R7 byte1", int'(host_rdata), 8'h00);
    chk("R7 drained", int'(fill_count), 0);

    // R10 R3 command capture
    mode_wr = 1; mode_val = 1; cyc(); mode_wr = 0;
    chk("R10 mode set", int'(cmd_mode), 1);
    for (int i = 0; i < 17; i++) op(1, 8'hC0 + 8'(i), 0);
    chk("R3 cmd_len saturates", int'(cmd_len), 16);
    chk("R3 fill untouched", int'(fill_count), 0);
    cmd_idx = 4'd0; #1;
    chk("R3 cmd byte 0", int'(cmd_byte), 8'hC0);
    cmd_idx = 4'd15; #1;
    chk("R3 cmd byte 15", int'(cmd_byte), 8'hCF);
    cmd_clr = 1; cyc(); cmd_clr = 0;
    chk("R10 cmd_clr", int'(cmd_len), 0);
    op(1, 8'hAB, 0);
    cmd_idx = 4'd0; #1;
    chk("R3 append after clear", int'(cmd_byte), 8'hAB);
    chk("R3 len 1", int'(cmd_len), 1);

    // R1 reset clears mode and length
    do_reset();
    chk("R1 mode cleared", int'(cmd_mode), 0);
    chk("R1 cmd_len cleared", int'(cmd_len), 0);
    op(1, 8'h44, 0);
    chk("R1 normal write after reset", int'(fill_count), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule